// File: doc/BRIEF.md
# Idle-Mode Clock Source Controller

This block moves a processor core between its run state and a low-power idle state. In idle the core clock is gated off, while the peripherals keep running from the internal oscillator multiplexer. Software asks for idle by pulsing a sleep request with the idle-enable bit set and the upper clock-select bit high. A wake event brings the core back after a fixed delay, on the same internal clock.

The block also drives the enables of the clock sources. The primary oscillator runs only while the multiplexer selects it, and its ready flag restarts from zero each time it is enabled. The internal high-frequency source runs whenever either the frequency-select field is non-zero or the source-select bit is set. It reports stable only after a programmable stabilization count. When that source is off, the multiplexer falls back to the low-frequency RC source. The RC source is also kept alive by the watchdog or the clock-monitor enable.

A wake that arrives while the internal source is still stabilizing is held, and the wake delay starts once the source is stable. All delays are parameters in clock cycles.

Top module: `idle_clk_ctrl`

## Requirements
- R1: In run, a sleep_req_i pulse with idle_en_i=1 and clk_sel_i[1]=1 (clk_sel_i[0] ignored) drops core_clk_en_o after the next edge, with periph_clk_en_o=1 and clk_mux_sel_o=1.
- R2: A sleep_req_i pulse with idle_en_i=0 or clk_sel_i[1]=0 has no effect, and wake_i in run has no effect: core_clk_en_o stays 1.
- R3: clk_mux_sel_o is 1 (internal) in idle, while waking, and in run when clk_sel_i[1]=1; otherwise it is 0 (primary). While it is 1, pri_osc_en_o=0 and pri_osc_rdy_o=0. pri_osc_rdy_o rises PRI_CYC edges after pri_osc_en_o is first sampled high.
- R4: int_osc_en_o = (freq_sel_i != 0) | int_src_i. When both are clear, int_stable_o stays 0.
- R5: int_stable_o rises STAB_CYC edges after int_osc_en_o is first sampled high, and clears as soon as the source is disabled.
- R6: If the internal source is already stable when idle is entered, int_stable_o stays 1 with no gap.
- R7: A wake_i sampled in idle while the source is ready (stable, or internal source off) raises core_clk_en_o WAKE_CYC+1 edges later. periph_clk_en_o stays 1 and clk_mux_sel_o stays 1 throughout and after, because clk_sel_i is left unchanged.
- R8: A wake_i sampled in idle before int_stable_o rises is held. core_clk_en_o then rises WAKE_CYC+2 edges after the edge at which int_stable_o goes high.
- R9: lf_rc_en_o is 1 when wdt_en_i or clk_mon_en_i is set, or when the internal mux is selected with the internal source off.
- R10: While rst_ni=0: core_clk_en_o=0, periph_clk_en_o=0, clk_mux_sel_o=0, pri_osc_en_o=1 and pri_osc_rdy_o=0. Both clock enables are 1 after the first edge following release, with clk_sel_i=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_req_i | input | 1 | One-cycle sleep request strobe |
| idle_en_i | input | 1 | Idle instead of full sleep |
| clk_sel_i | input | 2 | Clock select; bit 1 picks the internal mux, bit 0 ignored |
| freq_sel_i | input | FSEL_W | Internal frequency select |
| int_src_i | input | 1 | Internal source select |
| wake_i | input | 1 | Wake event |
| wdt_en_i | input | 1 | Watchdog enabled |
| clk_mon_en_i | input | 1 | Fail-safe clock monitor enabled |
| core_clk_en_o | output | 1 | Core clock gate enable |
| periph_clk_en_o | output | 1 | Peripheral clock gate enable |
| clk_mux_sel_o | output | 1 | 1 = internal mux, 0 = primary oscillator |
| pri_osc_en_o | output | 1 | Primary oscillator enable |
| pri_osc_rdy_o | output | 1 | Primary oscillator status |
| int_osc_en_o | output | 1 | Internal high-frequency source enable |
| int_stable_o | output | 1 | Internal source stable |
| lf_rc_en_o | output | 1 | Low-frequency RC source enable |

## Verification
The properties assume inputs are known after reset and sample them only as they stand in the current cycle. The exception is the stable-hold rule, which also looks one cycle back at the source enable. The bench drives every input on the falling edge and pulses sleep_req_i and wake_i for one cycle only. It leaves clk_sel_i and idle_en_i unchanged while the core is stopped, so the mux-select checks in idle and wake rely only on state and not on those inputs. It also enables the internal source only before an idle entry or while idle. This keeps the held-wake case and the already-stable case separate.

// File: rtl/icc_pkg.sv
package icc_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_WAKE = 2'd2
  } icc_state_e;
endpackage

// File: rtl/icc_delay_cnt.sv
module icc_delay_cnt #(
  parameter int unsigned CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic done_o
);
  localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(CYC);

  logic [CW-1:0] cnt_q;

  // counts enabled edges, saturates at CYC, clears when enable drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!en_i)        cnt_q <= '0;
    else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = en_i && (cnt_q == LIM);
endmodule

// File: rtl/icc_intosc.sv
module icc_intosc #(
  parameter int unsigned FSEL_W   = 3,
  parameter int unsigned STAB_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FSEL_W-1:0] freq_sel_i,
  input  logic              int_src_i,
  input  logic              mux_int_i,
  input  logic              wdt_en_i,
  input  logic              clk_mon_en_i,
  output logic              int_en_o,
  output logic              stable_o,
  output logic              src_ready_o,
  output logic              lf_rc_en_o
);
  assign int_en_o = (freq_sel_i != '0) || int_src_i;

  icc_delay_cnt #(.CYC(STAB_CYC)) u_stab (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (int_en_o),
    .done_o (stable_o)
  );

  // with the HF source off the mux runs from the LF RC, nothing to wait for
  assign src_ready_o = !int_en_o || stable_o;
  assign lf_rc_en_o  = wdt_en_i || clk_mon_en_i || (mux_int_i && !int_en_o);
endmodule

// File: rtl/icc_mode_fsm.sv
module icc_mode_fsm
  import icc_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sleep_req_i,
  input  logic idle_en_i,
  input  logic clk_sel_hi_i,
  input  logic wake_i,
  input  logic src_ready_i,
  output logic core_clk_en_o,
  output logic periph_clk_en_o,
  output logic mux_int_o
);
  icc_state_e state_q, state_d;
  logic       pend_q, pend_d;
  logic       live_q;
  logic       wake_done;
  logic       wake_seen;

  icc_delay_cnt #(.CYC(WAKE_CYC)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (state_q == ST_WAKE),
    .done_o (wake_done)
  );

  assign wake_seen = wake_i || pend_q;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_RUN: begin
        pend_d = 1'b0;
        if (sleep_req_i && idle_en_i && clk_sel_hi_i) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (wake_seen) begin
          if (src_ready_i) begin
            state_d = ST_WAKE;
            pend_d  = 1'b0;
          end else begin
            pend_d  = 1'b1;
          end
        end
      end
      ST_WAKE: if (wake_done) state_d = ST_RUN;
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      pend_q  <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      live_q  <= 1'b1;
    end
  end

  assign core_clk_en_o   = live_q && (state_q == ST_RUN);
  assign periph_clk_en_o = live_q;
  assign mux_int_o       = (state_q != ST_RUN) || clk_sel_hi_i;
endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl #(
  parameter int unsigned FSEL_W   = 3,
  parameter int unsigned STAB_CYC = 16,
  parameter int unsigned WAKE_CYC = 8,
  parameter int unsigned PRI_CYC  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              idle_en_i,
  input  logic [1:0]        clk_sel_i,
  input  logic [FSEL_W-1:0] freq_sel_i,
  input  logic              int_src_i,
  input  logic              wake_i,
  input  logic              wdt_en_i,
  input  logic              clk_mon_en_i,
  output logic              core_clk_en_o,
  output logic              periph_clk_en_o,
  output logic              clk_mux_sel_o,
  output logic              pri_osc_en_o,
  output logic              pri_osc_rdy_o,
  output logic              int_osc_en_o,
  output logic              int_stable_o,
  output logic              lf_rc_en_o
);
  logic mux_int;
  logic src_ready;

  icc_mode_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .sleep_req_i     (sleep_req_i),
    .idle_en_i       (idle_en_i),
    .clk_sel_hi_i    (clk_sel_i[1]),
    .wake_i          (wake_i),
    .src_ready_i     (src_ready),
    .core_clk_en_o   (core_clk_en_o),
    .periph_clk_en_o (periph_clk_en_o),
    .mux_int_o       (mux_int)
  );

  icc_intosc #(.FSEL_W(FSEL_W), .STAB_CYC(STAB_CYC)) u_intosc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .freq_sel_i   (freq_sel_i),
    .int_src_i    (int_src_i),
    .mux_int_i    (mux_int),
    .wdt_en_i     (wdt_en_i),
    .clk_mon_en_i (clk_mon_en_i),
    .int_en_o     (int_osc_en_o),
    .stable_o     (int_stable_o),
    .src_ready_o  (src_ready),
    .lf_rc_en_o   (lf_rc_en_o)
  );

  // primary runs only while selected; status restarts on every enable
  icc_delay_cnt #(.CYC(PRI_CYC)) u_pri (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (pri_osc_en_o),
    .done_o (pri_osc_rdy_o)
  );

  assign clk_mux_sel_o = mux_int;
  assign pri_osc_en_o  = !mux_int;
endmodule

// File: rtl/icc_checker.sv
module icc_checker #(
  parameter int unsigned FSEL_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sleep_req_i,
  input logic              idle_en_i,
  input logic [1:0]        clk_sel_i,
  input logic [FSEL_W-1:0] freq_sel_i,
  input logic              int_src_i,
  input logic              wdt_en_i,
  input logic              clk_mon_en_i,
  input logic              core_clk_en_o,
  input logic              periph_clk_en_o,
  input logic              clk_mux_sel_o,
  input logic              pri_osc_en_o,
  input logic              pri_osc_rdy_o,
  input logic              int_osc_en_o,
  input logic              int_stable_o,
  input logic              lf_rc_en_o
);
  p_idle_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && idle_en_i && clk_sel_i[1] && core_clk_en_o)
      |=> (!core_clk_en_o && periph_clk_en_o && clk_mux_sel_o));

  p_sleep_ignored_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sleep_req_i && !(idle_en_i && clk_sel_i[1]) && core_clk_en_o) |=> core_clk_en_o);

  p_pri_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_mux_sel_o |-> (!pri_osc_en_o && !pri_osc_rdy_o));

  p_int_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((freq_sel_i == '0) && !int_src_i) |-> (!int_osc_en_o && !int_stable_o));

  p_stable_needs_en_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_stable_o |-> int_osc_en_o);

  p_stable_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_osc_en_o && $past(int_osc_en_o) && $past(int_stable_o)) |-> int_stable_o);

  p_periph_internal_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_clk_en_o && periph_clk_en_o) |-> clk_mux_sel_o);

  p_lf_rc_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_en_i || clk_mon_en_i) |-> lf_rc_en_o);
endmodule

bind idle_clk_ctrl icc_checker #(.FSEL_W(FSEL_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .sleep_req_i     (sleep_req_i),
  .idle_en_i       (idle_en_i),
  .clk_sel_i       (clk_sel_i),
  .freq_sel_i      (freq_sel_i),
  .int_src_i       (int_src_i),
  .wdt_en_i        (wdt_en_i),
  .clk_mon_en_i    (clk_mon_en_i),
  .core_clk_en_o   (core_clk_en_o),
  .periph_clk_en_o (periph_clk_en_o),
  .clk_mux_sel_o   (clk_mux_sel_o),
  .pri_osc_en_o    (pri_osc_en_o),
  .pri_osc_rdy_o   (pri_osc_rdy_o),
  .int_osc_en_o    (int_osc_en_o),
  .int_stable_o    (int_stable_o),
  .lf_rc_en_o      (lf_rc_en_o)
);

// File: tb/idle_clk_ctrl_tb_top.sv
module idle_clk_ctrl_tb_top;
  localparam int unsigned FSEL_W = 3;
  localparam int unsigned STAB   = 4;
  localparam int unsigned WAKE   = 3;
  localparam int unsigned PRI    = 5;

  logic              clk_i = 1'b0;
  logic              rst_ni;
  logic              sleep_req_i, idle_en_i, int_src_i, wake_i, wdt_en_i, clk_mon_en_i;
  logic [1:0]        clk_sel_i;
  logic [FSEL_W-1:0] freq_sel_i;
  logic core_clk_en_o, periph_clk_en_o, clk_mux_sel_o, pri_osc_en_o;
  logic pri_osc_rdy_o, int_osc_en_o, int_stable_o, lf_rc_en_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk_i = ~clk_i;

  idle_clk_ctrl #(.FSEL_W(FSEL_W), .STAB_CYC(STAB), .WAKE_CYC(WAKE), .PRI_CYC(PRI)) dut_i (
    .clk_i, .rst_ni, .sleep_req_i, .idle_en_i, .clk_sel_i, .freq_sel_i, .int_src_i,
    .wake_i, .wdt_en_i, .clk_mon_en_i, .core_clk_en_o, .periph_clk_en_o, .clk_mux_sel_o,
    .pri_osc_en_o, .pri_osc_rdy_o, .int_osc_en_o, .int_stable_o, .lf_rc_en_o
  );

  // {freq_sel[2:0], int_src, wdt, mon, exp_int_en, exp_lf_en}
  localparam int NV = 7;
  localparam logic [7:0] VEC [NV] = '{
    {3'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    {3'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    {3'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    {3'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1},
    {3'd5, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1},
    {3'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse_sleep();
    sleep_req_i = 1'b1; step(1); sleep_req_i = 1'b0;
  endtask

  task automatic pulse_wake();
    wake_i = 1'b1; step(1); wake_i = 1'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; sleep_req_i = 1'b0; idle_en_i = 1'b0; clk_sel_i = 2'b00;
    freq_sel_i = '0; int_src_i = 1'b0; wake_i = 1'b0; wdt_en_i = 1'b0; clk_mon_en_i = 1'b0;
    step(2);
    chk("R10 core in reset", core_clk_en_o, 1'b0);
    chk("R10 periph in reset", periph_clk_en_o, 1'b0);
    chk("R10 mux in reset", clk_mux_sel_o, 1'b0);
    chk("R10 pri en in reset", pri_osc_en_o, 1'b1);
    chk("R10 pri rdy in reset", pri_osc_rdy_o, 1'b0);
    rst_ni = 1'b1;
    step(1);
    chk("R10 core after release", core_clk_en_o, 1'b1);
    chk("R10 periph after release", periph_clk_en_o, 1'b1);
    step(PRI - 2);
    chk("R3 pri rdy before count", pri_osc_rdy_o, 1'b0);
    step(1);
    chk("R3 pri rdy at count", pri_osc_rdy_o, 1'b1);

    // R2: requests that must not stop the core
    idle_en_i = 1'b0; clk_sel_i = 2'b10; pulse_sleep();
    chk("R2 sleep with idle_en=0", core_clk_en_o, 1'b1);
    idle_en_i = 1'b1; clk_sel_i = 2'b01; pulse_sleep();
    chk("R2 sleep with clk_sel[1]=0", core_clk_en_o, 1'b1);
    chk("R3 primary selected", pri_osc_en_o, 1'b1);
    pulse_wake();
    chk("R2 wake in run", core_clk_en_o, 1'b1);

    // table: internal mux in run, source enables (R4, R9)
    clk_sel_i = 2'b10; idle_en_i = 1'b0;
    for (int i = 0; i < NV; i++) begin
      freq_sel_i = VEC[i][7:5]; int_src_i = VEC[i][4];
      wdt_en_i = VEC[i][3]; clk_mon_en_i = VEC[i][2];
      step(1);
      chk("R4 int osc enable", int_osc_en_o, VEC[i][1]);
      chk("R9 lf rc enable", lf_rc_en_o, VEC[i][0]);
      if (!VEC[i][1]) chk("R4 stable off", int_stable_o, 1'b0);
    end
    chk("R3 mux internal", clk_mux_sel_o, 1'b1);
    chk("R3 pri off", pri_osc_en_o, 1'b0);
    chk("R3 pri rdy cleared", pri_osc_rdy_o, 1'b0);

    // R5 stabilization timing
    freq_sel_i = '0; int_src_i = 1'b0; wdt_en_i = 1'b0; clk_mon_en_i = 1'b0;
    step(1);
    freq_sel_i = 3'd3;
    step(STAB - 1);
    chk("R5 not yet stable", int_stable_o, 1'b0);
    step(1);
    chk("R5 stable", int_stable_o, 1'b1);

    // R1/R6 idle entry with stable source, lower select bit set
    idle_en_i = 1'b1; clk_sel_i = 2'b11; pulse_sleep();
    chk("R1 core stopped", core_clk_en_o, 1'b0);
    chk("R1 periph running", periph_clk_en_o, 1'b1);
    chk("R1 mux internal", clk_mux_sel_o, 1'b1);
    chk("R6 stable kept", int_stable_o, 1'b1);

    // R7 wake with ready source
    pulse_wake();
    chk("R7 core off at wake", core_clk_en_o, 1'b0);
    step(WAKE);
    chk("R7 core off in delay", core_clk_en_o, 1'b0);
    chk("R7 periph on in delay", periph_clk_en_o, 1'b1);
    step(1);
    chk("R7 core resumed", core_clk_en_o, 1'b1);
    chk("R7 mux still internal", clk_mux_sel_o, 1'b1);

    // R8 wake during stabilization
    freq_sel_i = '0; step(1);
    freq_sel_i = 3'd1; pulse_sleep();
    pulse_wake();
    chk("R8 not stable at wake", int_stable_o, 1'b0);
    step(STAB - 2);
    chk("R8 stable now", int_stable_o, 1'b1);
    chk("R8 core held", core_clk_en_o, 1'b0);
    step(WAKE + 1);
    chk("R8 core before delay end", core_clk_en_o, 1'b0);
    step(1);
    chk("R8 core resumed", core_clk_en_o, 1'b1);

    // idle on the LF RC path (R4, R9, R7)
    freq_sel_i = '0; int_src_i = 1'b0; step(1);
    pulse_sleep();
    chk("R9 lf rc in idle", lf_rc_en_o, 1'b1);
    chk("R4 stable clear in idle", int_stable_o, 1'b0);
    pulse_wake();
    step(WAKE);
    chk("R7 lf core off in delay", core_clk_en_o, 1'b0);
    step(1);
    chk("R7 lf core resumed", core_clk_en_o, 1'b1);

    // R3 return to primary
    clk_sel_i = 2'b00; step(1);
    chk("R3 mux primary", clk_mux_sel_o, 1'b0);
    chk("R3 pri restart not ready", pri_osc_rdy_o, 1'b0);
    step(PRI - 1);
    chk("R3 pri ready again", pri_osc_rdy_o, 1'b1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule